// File: doc/BRIEF.md
# Four-Screen Pattern and Nametable Address Router

This block sits on the picture-processor side of a cartridge that carries 32 KB of its own character RAM. The picture processor presents a 14-bit address and a write strobe. The bank register presents two bank-select bits. From these the block produces the 15-bit address for the character RAM, a write enable for it, and chip enables for both the cartridge RAM and the console's nametable RAM.

A parameter selects one of two wirings. In the normal wiring the cartridge RAM serves only the pattern tables at `$0000-$1FFF`, and the console RAM serves everything above. In the four-screen wiring the console RAM is switched off. Address bit 13 is ORed into both bank address lines, so every access at `$2000` and above lands in the last 8 KB bank. That bank then holds four separate 1 KB nametables at `$2000-$2FFF` and a free scratch area at `$3000-$3EFF`.

The palette window at `$3F00-$3FFF` belongs to the picture processor, so writes there never reach the RAM. The four-screen wiring is only meaningful with the full 32 KB fitted.

Top module: `chr_nt_router`

## Requirements
- R1: In four-screen mode, any address with bit 13 set drives RAM address bits [14:13] to `2'b11`, and RAM address bits [12:0] copy the input address bits [12:0].
- R2: In four-screen mode, with address bit 13 clear, RAM address bits [14:13] equal the bank bits (bit 14 from bank bit 1, bit 13 from bank bit 0).
- R3: In four-screen mode, the cartridge RAM enable is always 1 and the console nametable enable is always 0.
- R4: In normal mode, the cartridge RAM enable equals the inverse of address bit 13, and the console nametable enable equals address bit 13. RAM address bits [14:13] equal the bank bits.
- R5: In four-screen mode, addresses `$2000-$2FFF` map one to one onto RAM `$6000-$6FFF`, giving four distinct 1 KB nametables.
- R6: In four-screen mode, addresses `$3000-$3EFF` map onto RAM `$7000-$7EFF`, separate from the nametables.
- R7: The RAM write enable is 1 only when the write strobe is 1, the cartridge RAM is enabled, and the address is below `$3F00`. It is never 1 in the palette window `$3F00-$3FFF`.
- R8: In four-screen mode with both bank bits set, pattern table 0 (`$0000-$0FFF`) lands on RAM `$6000-$6FFF`, the same cells as the nametables. Pattern table 1 at `$1F00-$1FFF` reaches RAM `$7F00-$7FFF` and may be written there.
- R9: In four-screen mode, values written to the four nametables and to scratch RAM read back unchanged, and no two of those regions alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ppu_addr | input | 14 | Picture-processor address |
| ppu_we | input | 1 | Picture-processor write strobe, active high |
| bank_sel | input | 2 | Character bank bits from the bank register |
| chr_addr | output | 15 | Cartridge character RAM address |
| chr_en | output | 1 | Cartridge character RAM chip enable, active high |
| chr_we | output | 1 | Cartridge character RAM write enable, active high |
| nt_en | output | 1 | Console nametable RAM chip enable, active high |

## Verification
The block is purely combinational, so a wrong routing shows at the ports in the same cycle the address is applied. A bank line that is not forced high would make a nametable access land in a pattern bank. A missing palette gate would let a write at `$3Fxx` corrupt the top of the last bank. A dropped OR would let nametables alias each other or the scratch area, and that only becomes visible when an earlier write is read back. For this reason the bench keeps a RAM model fed from the outputs and reads every region back after writing all of them.

// File: rtl/chr_nt_router.sv
module chr_nt_router #(
  parameter bit FOUR_SCREEN = 1'b1,
  parameter int PPU_AW      = 14,
  parameter int CHR_AW      = 15
) (
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_we,
  input  logic [1:0]        bank_sel,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_en,
  output logic              chr_we,
  output logic              nt_en
);
  localparam int PAGE_LSB = PPU_AW - 6;

  logic hi_half;
  logic palette;
  logic [1:0] bank_lines;

  assign hi_half = ppu_addr[PPU_AW-1];
  assign palette = &ppu_addr[PPU_AW-1:PAGE_LSB];

  generate
    if (FOUR_SCREEN) begin : g_four
      assign bank_lines = bank_sel | {2{hi_half}};
      assign chr_en     = 1'b1;
      assign nt_en      = 1'b0;
    end else begin : g_norm
      assign bank_lines = bank_sel;
      assign chr_en     = ~hi_half;
      assign nt_en      = hi_half;
    end
  endgenerate

  assign chr_addr = {bank_lines, ppu_addr[PPU_AW-2:0]};
  assign chr_we   = ppu_we & chr_en & ~palette;
endmodule

module chr_nt_router_chk #(
  parameter bit FOUR_SCREEN = 1'b1
) (
  input logic [13:0] ppu_addr,
  input logic        ppu_we,
  input logic [1:0]  bank_sel,
  input logic [14:0] chr_addr,
  input logic        chr_en,
  input logic        chr_we,
  input logic        nt_en
);
  always_comb begin
    // R1
    hi_bank_chk: assert (!(FOUR_SCREEN && ppu_addr[13]) || chr_addr[14:13] == 2'b11);
    // R3
    console_off_chk: assert (!FOUR_SCREEN || (chr_en && !nt_en));
    // R4
    exclusive_en_chk: assert (FOUR_SCREEN || (chr_en != nt_en));
    // R7
    we_gate_chk: assert (!chr_we || (ppu_we && chr_en));
    // R7
    palette_chk: assert (!(ppu_addr[13:8] == 6'h3F) || !chr_we);
    // R8
    alias_bank_chk: assert (!(FOUR_SCREEN && bank_sel == 2'b11) || chr_addr[14:13] == 2'b11);
  end
endmodule

bind chr_nt_router chr_nt_router_chk #(.FOUR_SCREEN(FOUR_SCREEN)) chk (
  .ppu_addr(ppu_addr), .ppu_we(ppu_we), .bank_sel(bank_sel),
  .chr_addr(chr_addr), .chr_en(chr_en), .chr_we(chr_we), .nt_en(nt_en)
);

// File: tb/chr_nt_router_test.sv
module chr_nt_router_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [13:0] a;
  logic        we;
  logic [1:0]  bk;
  logic [14:0] fa, na;
  logic        fen, fwe, fnt, nen, nwe, nnt;
  int checks = 0;
  int errors = 0;
  logic [7:0] mem [int];

  chr_nt_router #(.FOUR_SCREEN(1'b1)) uut (
    .ppu_addr(a), .ppu_we(we), .bank_sel(bk),
    .chr_addr(fa), .chr_en(fen), .chr_we(fwe), .nt_en(fnt));

  chr_nt_router #(.FOUR_SCREEN(1'b0)) uut_n (
    .ppu_addr(a), .ppu_we(we), .bank_sel(bk),
    .chr_addr(na), .chr_en(nen), .chr_we(nwe), .nt_en(nnt));

  function automatic logic [14:0] exp_addr(bit fs, logic [13:0] ad, logic [1:0] b);
    logic [1:0] hi;
    hi = (fs && ad >= 14'h2000) ? 2'b11 : b;
    return {hi, ad[12:0]};
  endfunction

  function automatic logic exp_we(bit en, logic w, logic [13:0] ad);
    return w && en && (ad < 14'h3F00);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [13:0] ad, logic w, logic [1:0] b);
    @(negedge clk);
    a = ad; we = w; bk = b;
    #1;
  endtask

  task automatic check_all();
    logic [14:0] ef, en;
    ef = exp_addr(1, a, bk);
    en = exp_addr(0, a, bk);
    check(fa == ef, "R1/R2", fa, ef);
    check(fen == 1'b1 && fnt == 1'b0, "R3", {fen, fnt}, 2'b10);
    check(na == en, "R4 addr", na, en);
    check(nen == !a[13] && nnt == a[13], "R4 enables", {nen, nnt}, {!a[13], a[13]});
    check(fwe == exp_we(1, we, a), "R7 four", fwe, exp_we(1, we, a));
    check(nwe == exp_we(nen, we, a), "R7 normal", nwe, exp_we(nen, we, a));
  endtask

  task automatic mwrite(logic [13:0] ad, logic [1:0] b, logic [7:0] d);
    drive(ad, 1'b1, b);
    if (fwe) mem[int'(fa)] = d;
    drive(ad, 1'b0, b);
  endtask

  task automatic mread(logic [13:0] ad, logic [1:0] b, logic [7:0] e, string req);
    logic [7:0] v;
    drive(ad, 1'b0, b);
    v = mem.exists(int'(fa)) ? mem[int'(fa)] : 8'hxx;
    check(v === e, req, v, e);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = '0; we = 1'b0; bk = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // reset-like idle state, R7
    check(fwe == 1'b0 && nwe == 1'b0, "R7 idle", {fwe, nwe}, 0);

    // R5: each 1KB nametable lands on its own RAM page
    for (int i = 0; i < 4; i++) begin
      drive(14'h2000 + 14'(i * 14'h400) + 14'h0123, 1'b0, 2'b00);
      check(fa == 15'h6000 + 15'(i * 15'h400) + 15'h0123, "R5", fa,
            15'h6000 + 15'(i * 15'h400) + 15'h0123);
    end
    // R6
    drive(14'h3EFF, 1'b1, 2'b01);
    check(fa == 15'h7EFF, "R6", fa, 15'h7EFF);
    check(fwe == 1'b1, "R6 we", fwe, 1);
    // R7 palette boundaries
    drive(14'h3F00, 1'b1, 2'b10);
    check(fwe == 1'b0, "R7 palette lo", fwe, 0);
    drive(14'h3FFF, 1'b1, 2'b11);
    check(fwe == 1'b0, "R7 palette hi", fwe, 0);
    // R8 aliasing with both bank bits set
    drive(14'h0456, 1'b0, 2'b11);
    check(fa == 15'h6456, "R8 pt0", fa, 15'h6456);
    drive(14'h1F80, 1'b1, 2'b11);
    check(fa == 15'h7F80 && fwe == 1'b1, "R8 pt1", fa, 15'h7F80);
    // R4 normal mode bank
    drive(14'h1ABC, 1'b1, 2'b10);
    check(na == 15'h5ABC && nwe == 1'b1, "R4 bank", na, 15'h5ABC);
    drive(14'h2ABC, 1'b1, 2'b10);
    check(nwe == 1'b0 && nnt == 1'b1, "R4 upper", {nwe, nnt}, 2'b01);

    // random mix, R1 R2 R3 R4 R7
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 400; i++) begin
      drive(14'($urandom), 1'($urandom), 2'($urandom));
      check_all();
    end

    // R9: distinct values in four nametables and scratch, read back
    mwrite(14'h2010, 2'b00, 8'hA0);
    mwrite(14'h2410, 2'b01, 8'hA1);
    mwrite(14'h2810, 2'b10, 8'hA2);
    mwrite(14'h2C10, 2'b00, 8'hA3);
    mwrite(14'h3010, 2'b00, 8'hA4);
    mwrite(14'h3F10, 2'b00, 8'hEE);
    mread(14'h2010, 2'b00, 8'hA0, "R9 nt0");
    mread(14'h2410, 2'b00, 8'hA1, "R9 nt1");
    mread(14'h2810, 2'b00, 8'hA2, "R9 nt2");
    mread(14'h2C10, 2'b00, 8'hA3, "R9 nt3");
    mread(14'h3010, 2'b00, 8'hA4, "R9 scratch");
    // R7: palette write left the top page untouched
    mread(14'h1F10, 2'b11, 8'hxx, "R7 palette untouched");
    // R8: pattern table 0 in bank 3 sees nametable 0
    mread(14'h0010, 2'b11, 8'hA0, "R8 alias read");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule